// File: doc/BRIEF.md
# Triggered Trace Capture Ring with Hang Watchdog

This block sits beside a valid/ready bus link and keeps a rolling record of what the link did. Every qualifying cycle becomes one entry holding the valid bit, the ready bit and the data word, written into a ring of recent history. Older entries are overwritten, so the ring always holds the lead-up to whatever happens next.

A capture is ended by a trigger. Three sources feed it: a cross-trigger input from some other monitor, a snapshot request that may arrive from another clock domain, and an internal watchdog. The watchdog raises an alarm when the link has held valid without acceptance for a programmable number of cycles. After the trigger, a programmable number of further entries are written, and then the ring freezes. A post length of zero stops recording at the trigger cycle itself. The frozen history then streams out on a valid/ready port, oldest entry first, with the final entry marked. A re-arm input discards the history and starts a fresh capture.

Two capture modes exist. In accepted-beat mode, only cycles where valid and ready are both high are recorded. In raw mode, every cycle is recorded whatever the handshake does, so a link that is stuck shows up in the trace as a run of unanswered cycles.

Top module: `trace_freeze_buf`

## Requirements
- R1: After reset, `cap_state` is 0 (armed), `out_valid` is 0 and `hang_alarm` is 0.
- R2: When `raw_mode` is 0, an entry is written only in cycles where `bus_valid` and `bus_ready` are both 1. An entry is the bit vector {`bus_valid`, `bus_ready`, `bus_data`}, with valid in the top bit and ready in the bit below it.
- R3: When `raw_mode` is 1, one entry is written in every recording cycle, including cycles where the handshake does not complete.
- R4: The ring holds the newest DEPTH entries (64 by default, a power of two). When more are written, the oldest entries are lost.
- R5: An entry written in the cycle a trigger is taken is kept. After that, exactly `post_len` more entries are written and then recording stops. With `post_len` = 0, recording ends at the trigger cycle.
- R6: When frozen, the stored entries leave on `out_entry` from oldest to newest, one per cycle in which `out_valid` and `out_ready` are both 1. `out_last` is 1 only on the newest entry. While `out_ready` is 0, `out_valid` and `out_entry` hold.
- R7: A 1 on `ext_trig` at a clock edge, while the block is armed, takes a trigger at that edge.
- R8: A rising edge of `snap_req` passes through a two-stage synchronizer. The trigger is taken at the third clock edge after `snap_req` is first seen high.
- R9: `hang_alarm` is 1 once `bus_valid`=1 with `bus_ready`=0 has held for `hang_limit` consecutive cycles. It stays 1 while the stall lasts. An accepted beat or `bus_valid`=0 clears the count. A `hang_limit` of 0 disables the alarm. While the block is armed, the alarm takes a trigger.
- R10: Triggers from any source are ignored while `cap_state` is 1 (post-trigger), 2 (draining) or 3 (done).
- R11: `rearm` returns the block to the armed state from any state on the next edge. It empties the ring and clears the watchdog count, so the next drain holds only entries written after the re-arm.
- R12: `cap_state` encodes 0 armed, 1 post-trigger, 2 draining and 3 done. `out_valid` is 1 only in state 2, and the block moves to 3 once the last entry has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Observed link valid |
| bus_ready | input | 1 | Observed link ready |
| bus_data | input | DATA_W | Observed link data |
| raw_mode | input | 1 | 1 records every cycle, 0 records accepted beats only |
| ext_trig | input | 1 | Cross-trigger from another monitor |
| snap_req | input | 1 | Snapshot request from any clock domain, acted on at its rising edge |
| hang_limit | input | LIMIT_W | Stall length that raises the alarm, 0 disables it |
| post_len | input | $clog2(DEPTH)+1 | Entries written after the trigger |
| rearm | input | 1 | Restart capture with an empty ring |
| out_ready | input | 1 | Consumer ready for the trace stream |
| out_valid | output | 1 | Trace entry available |
| out_entry | output | DATA_W+2 | Trace entry {valid, ready, data} |
| out_last | output | 1 | Marks the newest entry of the stream |
| cap_state | output | 2 | Capture state, encoded as in R12 |
| hang_alarm | output | 1 | Watchdog alarm |

## Verification
The hardest situation to reach from the ports is the ring after it has wrapped, frozen at the exact trigger cycle, with a drain under backpressure. The stimulus writes 100 accepted beats with a trigger on the last one and `post_len` at zero, so the expected stream must begin 36 entries in. A bench-side model tracks the armed, post-trigger and stopped phases and records what it expects the ring to hold. Its queue is then compared beat by beat against the drained output, while `out_ready` toggles and a trigger is injected during the drain. The watchdog boundary is checked one cycle before and at the limit, and after a stall that an accepted beat broke.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } cap_st_e;
endpackage

// File: rtl/trc_snap_sync.sv
// Two-stage synchronizer followed by a rising-edge detector.
module trc_snap_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end

  assign pulse = sh[1] & ~sh[2];
endmodule

// File: rtl/trc_watchdog.sv
// Counts consecutive stalled cycles (valid without ready) and saturates at the limit.
module trc_watchdog #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               valid,
  input  logic               ready,
  input  logic [LIMIT_W-1:0] limit,
  output logic               alarm
);
  logic [LIMIT_W-1:0] cnt;
  logic               stalled;

  function automatic logic [LIMIT_W-1:0] stall_next(
    input logic [LIMIT_W-1:0] c,
    input logic [LIMIT_W-1:0] lim,
    input logic               st
  );
    if (!st)      return '0;
    if (c < lim)  return c + 1'b1;
    return c;
  endfunction

  assign stalled = valid & ~ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= stall_next(cnt, limit, stalled);
  end

  assign alarm = (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/trc_ring.sv
// Circular entry store with a fill count and a drain pointer loaded at freeze time.
module trc_ring #(
  parameter int DEPTH = 64,
  parameter int EW    = 10,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [EW-1:0]    wr_data,
  input  logic             load_rd,
  input  logic             rd_adv,
  output logic [EW-1:0]    rd_data,
  output logic [CNT_W-1:0] left
);
  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, wptr_n;
  logic [CNT_W-1:0] fill, fill_n;

  function automatic logic [CNT_W-1:0] fill_after(input logic [CNT_W-1:0] f, input logic wr);
    if (!wr)                    return f;
    if (f == CNT_W'(DEPTH))     return f;
    return f + 1'b1;
  endfunction

  // Oldest entry: DEPTH is a power of two, so a full ring maps to the write pointer.
  function automatic logic [AW-1:0] oldest_ptr(input logic [AW-1:0] wp, input logic [CNT_W-1:0] f);
    return wp - f[AW-1:0];
  endfunction

  assign wptr_n = wr_en ? wptr + 1'b1 : wptr;
  assign fill_n = fill_after(fill, wr_en);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      left <= '0;
    end else if (clr) begin
      fill <= '0;
      left <= '0;
    end else begin
      wptr <= wptr_n;
      fill <= fill_n;
      if (load_rd) begin
        rptr <= oldest_ptr(wptr_n, fill_n);
        left <= fill_n;
      end else if (rd_adv) begin
        rptr <= rptr + 1'b1;
        left <= left - 1'b1;
      end
    end
  end

  assign rd_data = mem[rptr];
endmodule

// File: rtl/trc_ctrl.sv
// Capture sequencer: armed, post-trigger window, drain, done.
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             trig,
  input  logic             rec_ok,
  input  logic [CNT_W-1:0] post_len,
  input  logic [CNT_W-1:0] left,
  input  logic             out_ready,
  output logic             wr_en,
  output logic             load_rd,
  output logic             rd_adv,
  output logic             out_valid,
  output logic             out_last,
  output logic             trig_take,
  output cap_st_e          state
);
  logic [CNT_W-1:0] post_left;
  logic             post_done;

  always_comb begin
    wr_en     = rec_ok && (state == ST_ARMED || state == ST_POST) && !rearm;
    trig_take = trig && (state == ST_ARMED) && !rearm;
    post_done = (state == ST_POST) && rec_ok && (post_left == CNT_W'(1)) && !rearm;
    load_rd   = (trig_take && post_len == '0) || post_done;
    out_valid = (state == ST_DRAIN) && (left != '0);
    out_last  = out_valid && (left == CNT_W'(1));
    rd_adv    = out_valid && out_ready && !rearm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ARMED;
      post_left <= '0;
    end else if (rearm) begin
      state     <= ST_ARMED;
      post_left <= '0;
    end else begin
      unique case (state)
        ST_ARMED: if (trig_take) begin
          state     <= (post_len == '0) ? ST_DRAIN : ST_POST;
          post_left <= post_len;
        end
        ST_POST: if (rec_ok) begin
          if (post_left == CNT_W'(1)) state <= ST_DRAIN;
          else                        post_left <= post_left - 1'b1;
        end
        ST_DRAIN: if (left == '0 || (rd_adv && left == CNT_W'(1))) state <= ST_DONE;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/trace_freeze_buf.sv
module trace_freeze_buf
  import trc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter int LIMIT_W = 16,
  localparam int EW     = DATA_W + 2,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_ready,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               raw_mode,
  input  logic               ext_trig,
  input  logic               snap_req,
  input  logic [LIMIT_W-1:0] hang_limit,
  input  logic [CNT_W-1:0]   post_len,
  input  logic               rearm,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [EW-1:0]      out_entry,
  output logic               out_last,
  output logic [1:0]         cap_state,
  output logic               hang_alarm
);
  logic          snap_pulse, trig_any, trig_take, rec_ok;
  logic          wr_en, load_rd, rd_adv;
  logic [CNT_W-1:0] left;
  logic [EW-1:0] entry;
  cap_st_e       st;

  assign entry    = {bus_valid, bus_ready, bus_data};
  assign rec_ok   = raw_mode | (bus_valid & bus_ready);
  assign trig_any = ext_trig | snap_pulse | hang_alarm;

  trc_snap_sync u_snap (
    .clk(clk), .rst_n(rst_n), .async_in(snap_req), .pulse(snap_pulse)
  );

  trc_watchdog #(.LIMIT_W(LIMIT_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clr(rearm), .valid(bus_valid), .ready(bus_ready),
    .limit(hang_limit), .alarm(hang_alarm)
  );

  trc_ring #(.DEPTH(DEPTH), .EW(EW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(rearm), .wr_en(wr_en), .wr_data(entry),
    .load_rd(load_rd), .rd_adv(rd_adv), .rd_data(out_entry), .left(left)
  );

  trc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .trig(trig_any), .rec_ok(rec_ok),
    .post_len(post_len), .left(left), .out_ready(out_ready), .wr_en(wr_en),
    .load_rd(load_rd), .rd_adv(rd_adv), .out_valid(out_valid), .out_last(out_last),
    .trig_take(trig_take), .state(st)
  );

  assign cap_state = st;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int EW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          rearm,
  input logic          out_ready,
  input logic          out_valid,
  input logic          out_last,
  input logic [EW-1:0] out_entry,
  input logic [1:0]    cap_state,
  input logic          hang_alarm,
  input logic          trig_take
);
  // R6
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rearm) |=> (out_valid && $stable(out_entry)));

  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R10
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_state != 2'd0 && !rearm) |=> (cap_state != 2'd0));

  // R11
  rearm_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (cap_state == 2'd0 && !out_valid));

  // R12
  valid_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cap_state == 2'd2));

  // R9
  alarm_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hang_alarm) |-> $past(bus_valid && !bus_ready));

  // R7
  take_leaves_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_take |=> (cap_state == 2'd1 || cap_state == 2'd2));
endmodule

bind trace_freeze_buf trc_checker #(.EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .rearm(rearm), .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
  .out_entry(out_entry), .cap_state(cap_state), .hang_alarm(hang_alarm),
  .trig_take(trig_take)
);

// File: tb/sim_trace_freeze_buf.sv
module sim_trace_freeze_buf;
  localparam int DW = 8, DEPTH = 64, LW = 16, EW = DW + 2, PW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bus_valid, bus_ready, raw_mode, ext_trig, snap_req, rearm, out_ready;
  logic [DW-1:0] bus_data;
  logic [LW-1:0] hang_limit;
  logic [PW-1:0] post_len;
  logic out_valid, out_last, hang_alarm;
  logic [EW-1:0] out_entry;
  logic [1:0] cap_state;

  trace_freeze_buf #(.DATA_W(DW), .DEPTH(DEPTH), .LIMIT_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_data(bus_data), .raw_mode(raw_mode), .ext_trig(ext_trig), .snap_req(snap_req),
    .hang_limit(hang_limit), .post_len(post_len), .rearm(rearm), .out_ready(out_ready),
    .out_valid(out_valid), .out_entry(out_entry), .out_last(out_last),
    .cap_state(cap_state), .hang_alarm(hang_alarm)
  );

  int n_chk = 0, n_fail = 0;
  logic [EW-1:0] hist[$];
  logic [EW-1:0] exp_q[$];
  int m_state;  // 0 armed, 1 post window, 2 stopped
  int m_post;

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Driver: applies one bus cycle and advances the expected-history model.
  task automatic step(bit v, bit r, logic [DW-1:0] d, bit ext, bit mt);
    bit qual;
    @(negedge clk);
    bus_valid = v; bus_ready = r; bus_data = d; ext_trig = ext;
    qual = raw_mode || (v && r);
    if (m_state != 2 && qual) hist.push_back({v, r, d});
    if (m_state == 0 && (ext || mt)) begin
      if (post_len == 0) m_state = 2;
      else begin m_state = 1; m_post = int'(post_len); end
    end else if (m_state == 1 && qual) begin
      m_post--;
      if (m_post == 0) m_state = 2;
    end
    @(posedge clk); #1;
    ext_trig = 1'b0;
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1; bus_valid = 1'b0; bus_ready = 1'b0;
    @(posedge clk); #1;
    rearm = 1'b0;
    hist.delete();
    m_state = 0;
    check(cap_state == 2'd0, "R11 state after rearm", cap_state, 0);
    check(out_valid == 1'b0, "R11 out_valid after rearm", out_valid, 0);
  endtask

  task automatic drain(bit bp, bit poke);
    int first;
    int k;
    check(cap_state == 2'd2, "R12 state at freeze", cap_state, 2);
    first = (hist.size() > DEPTH) ? hist.size() - DEPTH : 0;
    for (int i = first; i < hist.size(); i++) exp_q.push_back(hist[i]);
    k = 0;
    while (exp_q.size() != 0 && k < 1000) begin
      @(negedge clk);
      out_ready = bp ? (k % 3 != 1) : 1'b1;
      bus_valid = 1'b1; bus_ready = 1'b1; bus_data = 8'hEE;
      ext_trig = (poke && k == 2);
      k++;
    end
    @(negedge clk);
    out_ready = 1'b0; ext_trig = 1'b0; bus_valid = 1'b0; bus_ready = 1'b0;
    check(exp_q.size() == 0, "R6 drained all entries", exp_q.size(), 0);
    @(posedge clk); #1;
    check(cap_state == 2'd3, "R12 done after last beat", cap_state, 3);
    check(out_valid == 1'b0, "R12 no valid when done", out_valid, 0);
  endtask

  // Monitor: pops expected entries as accepted beats appear.
  always @(negedge clk) begin
    #5;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected beat", out_entry, -1);
      end else begin
        logic [EW-1:0] e;
        e = exp_q.pop_front();
        check(out_entry == e, "R6 entry order/content", out_entry, e);
        check(out_last == (exp_q.size() == 0), "R6 last marker", out_last, exp_q.size() == 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired: actual 100000 cycles expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_valid = 0; bus_ready = 0; bus_data = '0; raw_mode = 0;
    ext_trig = 0; snap_req = 0; hang_limit = '0; post_len = '0; rearm = 0; out_ready = 0;
    m_state = 0; m_post = 0;
    repeat (3) @(posedge clk); #1;
    check(cap_state == 2'd0, "R1 reset state", cap_state, 0);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(hang_alarm == 1'b0, "R1 reset alarm", hang_alarm, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R5 R7 R10: accepted-beat mode, post window of 3, trigger ignored in post and drain
    post_len = 7'd3;
    for (int i = 0; i < 10; i++) step(i % 3 != 2, i % 2 == 0, 8'(i), 1'b0, 1'b0);
    step(1'b1, 1'b1, 8'h40, 1'b1, 1'b0);
    check(cap_state == 2'd1, "R7 ext trigger taken", cap_state, 1);
    for (int i = 0; i < 12; i++) step(1'b1, i % 2 == 1, 8'h50 + 8'(i), i == 1, 1'b0);
    drain(1'b1, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    check(cap_state == 2'd3, "R10 trigger ignored when done", cap_state, 3);
    check(out_valid == 1'b0, "R10 no output when done", out_valid, 0);

    // R4: wrap, capture ends at trigger
    do_rearm();
    post_len = 7'd0;
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 8'(i), i == 99, 1'b0);
    drain(1'b0, 1'b0);

    // R11: rearm empties the ring
    do_rearm();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 8'hA0 + 8'(i), i == 4, 1'b0);
    drain(1'b1, 1'b0);

    // R3 R9: raw mode and watchdog trigger
    do_rearm();
    raw_mode = 1'b1; hang_limit = 16'd4; post_len = 7'd2;
    step(1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h02, 1'b0, 1'b0);
    check(hang_alarm == 1'b0, "R9 alarm low below limit", hang_alarm, 0);
    step(1'b1, 1'b1, 8'h03, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h04, 1'b0, 1'b0);
    check(hang_alarm == 1'b0, "R9 handshake cleared count", hang_alarm, 0);
    step(1'b0, 1'b0, 8'h05, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h06, 1'b0, 1'b0);
    check(hang_alarm == 1'b0, "R9 alarm low at limit-1", hang_alarm, 0);
    step(1'b1, 1'b0, 8'h06, 1'b0, 1'b0);
    check(hang_alarm == 1'b1, "R9 alarm at limit", hang_alarm, 1);
    check(cap_state == 2'd0, "R9 not yet triggered", cap_state, 0);
    step(1'b1, 1'b0, 8'h07, 1'b0, 1'b1);
    check(cap_state == 2'd1, "R9 alarm took trigger", cap_state, 1);
    step(1'b0, 1'b1, 8'h08, 1'b0, 1'b0);
    step(1'b1, 1'b1, 8'h09, 1'b0, 1'b0);
    drain(1'b1, 1'b0);
    raw_mode = 1'b0;

    // R9: limit zero disables
    hang_limit = '0;
    do_rearm();
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'h33, 1'b0, 1'b0);
    check(hang_alarm == 1'b0, "R9 disabled alarm", hang_alarm, 0);
    check(cap_state == 2'd0, "R9 disabled no trigger", cap_state, 0);

    // R8: synchronized snapshot request
    do_rearm();
    post_len = 7'd1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'h60 + 8'(i), 1'b0, 1'b0);
    snap_req = 1'b1;
    step(1'b1, 1'b0, 8'h66, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h67, 1'b0, 1'b0);
    check(cap_state == 2'd0, "R8 snapshot not yet taken", cap_state, 0);
    step(1'b1, 1'b1, 8'h68, 1'b0, 1'b1);
    check(cap_state == 2'd1, "R8 snapshot taken", cap_state, 1);
    step(1'b1, 1'b1, 8'h69, 1'b0, 1'b0);
    snap_req = 1'b0;
    drain(1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule